// File: doc/BRIEF.md
# Expansion Memory Configuration Responder

This block lets one add-on memory board take part in the power-up configuration handshake of a 16-bit, 24-bit-address bus. The board starts out visible. While it is visible and a memory size is strapped, the block answers accesses in the 64 KB configuration page starting at 0xE80000. Reads return identification nibbles. Each logical 8-bit register is spread over two word addresses, one nibble each, and the nibble always travels on the top four data lines.

Host software either writes a base address to the board or tells it to shut up. Both writes remove the board from the configuration page until the next reset. After a base-address write, the block decodes a relocatable memory window whose length equals the strapped size. For every access inside that window it raises a select and supplies the byte offset into the board's array. The block decodes only. The array itself and the bus acknowledge logic of other devices sit outside it.

Top module: `xcfg_mem_responder`

## Requirements
- R1: `cfg_ack` is high only while `bus_strobe` is high, `bus_addr[23:16]` equals 0xE8, the board is still in the configuration page, and the strap is valid. No other address acknowledges.
- R2: On an acknowledged read, `cfg_rdata` equals 0x0FFF OR (nibble << 12). Whenever no read is acknowledged, `cfg_rdata` is 0x0000.
- R3: The register offset is `bus_addr[7:0]` with bit 0 forced to zero. Address bit 0 and address bits 15 to 8 do not change which register is selected.
- R4: Offset 0x00 reads nibble 0xE. Any offset without a defined meaning reads 0xF.
- R5: Offset 0x02 reads the size code. The `size_sel` encoding is 1 = 1 MB, 2 = 2 MB, 3 = 4 MB and 4 = 8 MB, and these read codes 5, 6, 7 and 0 respectively.
- R6: Offsets 0x10 and 0x12 read 0xA. Offsets 0x14 and 0x16 read 0xB.
- R7: An acknowledged write to offset 0x48 does three things. It captures `bus_wdata[15:8]` as base address bits 23 to 16. It maps a window of the strapped size at that base. It removes the board from the configuration page.
- R8: An acknowledged write to any offset from 0x4C to 0x4F removes the board from the configuration page and maps no memory. Writes to 0x4A and 0x50 are not shut-up commands.
- R9: With `size_sel` at 0 or at 5 to 7, the block never acknowledges, and writes in the page have no effect.
- R10: Once mapped, a strobed access with base ≤ address < base + size raises `mem_sel`, and `mem_offset` equals address − base. Any other access keeps `mem_sel` low.
- R11: Reset returns the block to visible and unmapped.
- R12: An acknowledged write to any other offset changes nothing. The board stays visible and unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Access valid this cycle |
| size_sel | input | 3 | Strapped memory size (0 = none) |
| cfg_ack | output | 1 | Configuration register access claimed |
| cfg_rdata | output | 16 | Configuration read data |
| mem_sel | output | 1 | Access hits the mapped memory window |
| mem_offset | output | 23 | Byte offset into the memory array |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Odd addresses and upper page bits.** A decoder that uses the full address would return 0xF instead of the type or size nibble.
- **Offsets just outside the shut-up range.** Writes to 0x4A and 0x50 sit on either side of the shut-up range. A range compare that is off by one would hide the board on one of them.
- **Window edges.** The bench tests base − 1, base + size − 1 and base + size. This catches off-by-one window limits and a missing carry when the window ends at the top of the address space, as it does for the 8 MB case.
- **Writes when unstrapped or invisible.** A base write while the strap is invalid must leave the board visible afterwards. After a shut-up, an access at address 0 must not hit. Getting either wrong shows up as a stale acknowledge or a phantom select.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

    typedef enum logic [2:0] {
        SZ_NONE = 3'd0,
        SZ_1M   = 3'd1,
        SZ_2M   = 3'd2,
        SZ_4M   = 3'd3,
        SZ_8M   = 3'd4
    } size_sel_e;

    typedef struct packed {
        logic       visible;
        logic       mapped;
        logic [7:0] base;
        logic [2:0] map_sel;
    } xcfg_state_t;

    function automatic logic size_is_valid(input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd4);
    endfunction

    // Nibble reported in the size register.
    function automatic logic [3:0] size_code(input logic [2:0] s);
        case (s)
            SZ_1M:   return 4'h5;
            SZ_2M:   return 4'h6;
            SZ_4M:   return 4'h7;
            SZ_8M:   return 4'h0;
            default: return 4'hF;
        endcase
    endfunction

    // log2 of the window length in bytes (1 MB = 2^20).
    function automatic logic [4:0] size_log2(input logic [2:0] s);
        return 5'd19 + {2'b00, s};
    endfunction

endpackage

// File: rtl/xcfg_id_rom.sv
module xcfg_id_rom #(
    parameter logic [3:0] TYPE_NIB = 4'hE,
    parameter logic [3:0] MFG_HI   = 4'hA,
    parameter logic [3:0] MFG_LO   = 4'hB
) (
    input  logic [7:0] reg_off,
    input  logic [3:0] size_nib,
    output logic [3:0] nibble
);
    always_comb begin
        case (reg_off)
            8'h00:        nibble = TYPE_NIB;
            8'h02:        nibble = size_nib;
            8'h10, 8'h12: nibble = MFG_HI;
            8'h14, 8'h16: nibble = MFG_LO;
            default:      nibble = 4'hF;
        endcase
    end
endmodule

// File: rtl/xcfg_win_decode.sv
module xcfg_win_decode #(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 8,
    parameter int LOG_W  = 5
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [LOG_W-1:0]  win_log2,
    output logic              hit,
    output logic [ADDR_W-2:0] offset
);
    localparam int SHIFT = ADDR_W - BASE_W;
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] lo, hi, a_ext, diff;

    always_comb begin
        lo     = {1'b0, base, {SHIFT{1'b0}}};
        hi     = lo + (EXT_W'(1) << win_log2);
        a_ext  = {1'b0, addr};
        diff   = a_ext - lo;
        hit    = en && (a_ext >= lo) && (a_ext < hi);
        offset = diff[ADDR_W-2:0];
    end
endmodule

// File: rtl/xcfg_mem_responder.sv
module xcfg_mem_responder #(
    parameter int         ADDR_W   = 24,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] CFG_PAGE = 8'hE8,
    parameter logic [3:0] MFG_HI   = 4'hA,
    parameter logic [3:0] MFG_LO   = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rnw,
    input  logic              bus_strobe,
    input  logic [2:0]        size_sel,
    output logic              cfg_ack,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mem_sel,
    output logic [ADDR_W-2:0] mem_offset
);
    import xcfg_pkg::*;

    localparam int         PAGE_W    = 8;
    localparam int         FILL_W    = DATA_W - 4;
    localparam logic [7:0] OFF_BASE  = 8'h48;
    localparam logic [7:0] OFF_SHUT0 = 8'h4C;
    localparam logic [7:0] OFF_SHUT1 = 8'h50;

    xcfg_state_t st_d, st_q;

    logic       in_page;
    logic       cfg_live;
    logic [7:0] reg_off;
    logic [3:0] nib;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-PAGE_W-1:0];

    xcfg_id_rom #(
        .TYPE_NIB (4'hE),
        .MFG_HI   (MFG_HI),
        .MFG_LO   (MFG_LO)
    ) u_rom (
        .reg_off  (reg_off),
        .size_nib (size_code(size_sel)),
        .nibble   (nib)
    );

    xcfg_win_decode #(
        .ADDR_W (ADDR_W),
        .BASE_W (PAGE_W),
        .LOG_W  (5)
    ) u_win (
        .en       (bus_strobe && st_q.mapped),
        .addr     (bus_addr),
        .base     (st_q.base),
        .win_log2 (size_log2(st_q.map_sel)),
        .hit      (mem_sel),
        .offset   (mem_offset)
    );

    always_comb begin
        in_page   = bus_addr[ADDR_W-1 -: PAGE_W] == CFG_PAGE;
        reg_off   = {bus_addr[7:1], 1'b0};
        cfg_live  = st_q.visible && size_is_valid(size_sel);
        cfg_ack   = bus_strobe && in_page && cfg_live;
        cfg_rdata = (cfg_ack && bus_rnw) ? {nib, {FILL_W{1'b1}}} : '0;

        st_d = st_q;
        if (cfg_ack && !bus_rnw) begin
            if (reg_off >= OFF_SHUT0 && reg_off < OFF_SHUT1) begin
                st_d.visible = 1'b0;
            end
            if (reg_off == OFF_BASE) begin
                st_d.visible = 1'b0;
                st_d.mapped  = 1'b1;
                st_d.base    = bus_wdata[DATA_W-1 -: PAGE_W];
                st_d.map_sel = size_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{visible: 1'b1, mapped: 1'b0, base: '0, map_sel: SZ_NONE};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xcfg_mem_responder_chk.sv
module xcfg_mem_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] bus_addr,
    input logic        bus_rnw,
    input logic        bus_strobe,
    input logic [2:0]  size_sel,
    input logic        cfg_ack,
    input logic [15:0] cfg_rdata,
    input logic        mem_sel
);
    AST_ACK_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> (bus_strobe && bus_addr[23:16] == 8'hE8)); // R1
    AST_RDATA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ack && bus_rnw) |-> (cfg_rdata[11:0] == 12'hFFF)); // R2
    AST_TYPE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ack && bus_rnw && bus_addr[7:1] == 7'h00) |-> (cfg_rdata[15:12] == 4'hE)); // R4
    AST_BASE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ack && !bus_rnw && bus_addr[7:1] == 7'h24) |=> !cfg_ack); // R7
    AST_SHUTUP_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ack && !bus_rnw && bus_addr[7:2] == 6'h13) |=> !cfg_ack); // R8
    AST_NO_STRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(size_sel >= 3'd1 && size_sel <= 3'd4) |-> !cfg_ack); // R9
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ack && mem_sel)); // R10
    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> bus_strobe); // R10
endmodule

bind xcfg_mem_responder xcfg_mem_responder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rnw    (bus_rnw),
    .bus_strobe (bus_strobe),
    .size_sel   (size_sel),
    .cfg_ack    (cfg_ack),
    .cfg_rdata  (cfg_rdata),
    .mem_sel    (mem_sel)
);

// File: tb/sim_xcfg_mem_responder.sv
`timescale 1ns/1ps
module sim_xcfg_mem_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rnw = 1'b1;
    logic        bus_strobe = 1'b0;
    logic [2:0]  size_sel = 3'd2;
    logic        cfg_ack, mem_sel;
    logic [15:0] cfg_rdata;
    logic [22:0] mem_offset;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xcfg_mem_responder u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rnw(bus_rnw), .bus_strobe(bus_strobe), .size_sel(size_sel),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .mem_sel(mem_sel), .mem_offset(mem_offset)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bus_strobe = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Combinational strobe sample; no clock edge occurs while strobed.
    task automatic probe(input logic [23:0] a, input bit strobe,
                         output logic ack, output logic [15:0] rd,
                         output logic sel, output logic [22:0] off);
        @(negedge clk);
        bus_addr = a; bus_rnw = 1'b1; bus_strobe = strobe;
        #1;
        ack = cfg_ack; rd = cfg_rdata; sel = mem_sel; off = mem_offset;
        bus_strobe = 1'b0;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_rnw = 1'b0; bus_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_strobe = 1'b0; bus_rnw = 1'b1;
    endtask

    task automatic expect_read(input logic [23:0] a, input logic [15:0] exp, input string req);
        logic ack, sel; logic [15:0] rd; logic [22:0] off;
        probe(a, 1'b1, ack, rd, sel, off);
        check(ack == 1'b1, req, {31'd0, ack}, 32'd1);
        check(rd == exp, req, {16'd0, rd}, {16'd0, exp});
    endtask

    task automatic expect_silent(input logic [23:0] a, input bit strobe, input string req);
        logic ack, sel; logic [15:0] rd; logic [22:0] off;
        probe(a, strobe, ack, rd, sel, off);
        check(ack == 1'b0, req, {31'd0, ack}, 32'd0);
        check(rd == 16'h0000, req, {16'd0, rd}, 32'd0);
    endtask

    task automatic expect_mem(input logic [23:0] a, input bit strobe, input bit exp_sel,
                              input logic [22:0] exp_off, input string req);
        logic ack, sel; logic [15:0] rd; logic [22:0] off;
        probe(a, strobe, ack, rd, sel, off);
        check(sel == exp_sel, req, {31'd0, sel}, {31'd0, exp_sel});
        if (exp_sel) check(off == exp_off, req, {9'd0, off}, {9'd0, exp_off});
    endtask

    task automatic t_reset_state();
        size_sel = 3'd2;
        do_reset();
        expect_read(24'hE80000, 16'hEFFF, "R11 visible after reset / R4 type");
        expect_mem(24'h000000, 1'b1, 1'b0, '0, "R11 unmapped after reset");
    endtask

    task automatic t_id_regs();
        expect_read(24'hE80002, 16'h6FFF, "R5 size 2MB code");
        expect_read(24'hE80010, 16'hAFFF, "R6 mfg 0x10");
        expect_read(24'hE80012, 16'hAFFF, "R6 mfg 0x12");
        expect_read(24'hE80014, 16'hBFFF, "R6 mfg 0x14");
        expect_read(24'hE80016, 16'hBFFF, "R6 mfg 0x16");
        expect_read(24'hE80020, 16'hFFFF, "R4 undefined offset");
        expect_read(24'hE80001, 16'hEFFF, "R3 odd address");
        expect_read(24'hE80003, 16'h6FFF, "R3 odd size address");
        expect_read(24'hE8FF00, 16'hEFFF, "R3 upper page bits ignored");
        expect_read(24'hE80018, 16'hFFFF, "R2 fill with ones");
    endtask

    task automatic t_size_codes();
        size_sel = 3'd1; expect_read(24'hE80002, 16'h5FFF, "R5 1MB");
        size_sel = 3'd3; expect_read(24'hE80002, 16'h7FFF, "R5 4MB");
        size_sel = 3'd4; expect_read(24'hE80002, 16'h0FFF, "R5 8MB");
        size_sel = 3'd0; expect_silent(24'hE80000, 1'b1, "R9 no size");
        size_sel = 3'd6; expect_silent(24'hE80000, 1'b1, "R9 invalid strap");
        size_sel = 3'd2;
    endtask

    task automatic t_outside();
        expect_silent(24'hE90000, 1'b1, "R1 page above");
        expect_silent(24'hE7FFFE, 1'b1, "R1 page below");
        expect_silent(24'hE80000, 1'b0, "R1 no strobe");
    endtask

    task automatic t_other_writes();
        do_write(24'hE80040, 16'h5500);
        expect_read(24'hE80000, 16'hEFFF, "R12 other write keeps visible");
        expect_mem(24'h550000, 1'b1, 1'b0, '0, "R12 other write no map");
        do_write(24'hE8004A, 16'h5500);
        expect_read(24'hE80000, 16'hEFFF, "R8 0x4A not shut-up");
        do_write(24'hE80050, 16'h5500);
        expect_read(24'hE80000, 16'hEFFF, "R8 0x50 not shut-up");
    endtask

    task automatic t_map_2m();
        do_write(24'hE80048, 16'h20FF);
        expect_silent(24'hE80000, 1'b1, "R7 hidden after base write");
        expect_mem(24'h200000, 1'b1, 1'b1, 23'h000000, "R10 window start");
        expect_mem(24'h3FFFFF, 1'b1, 1'b1, 23'h1FFFFF, "R10 window last byte");
        expect_mem(24'h400000, 1'b1, 1'b0, '0, "R10 past window end");
        expect_mem(24'h1FFFFF, 1'b1, 1'b0, '0, "R10 below base");
        expect_mem(24'h200010, 1'b0, 1'b0, '0, "R10 no strobe");
        expect_mem(24'h212346, 1'b1, 1'b1, 23'h012346, "R7 base from upper byte");
        do_write(24'hE8004C, 16'h0000);
        expect_mem(24'h200000, 1'b1, 1'b1, 23'h000000, "R7 stays mapped");
    endtask

    task automatic t_reset_after_map();
        do_reset();
        expect_read(24'hE80000, 16'hEFFF, "R11 visible again");
        expect_mem(24'h200000, 1'b1, 1'b0, '0, "R11 unmapped again");
    endtask

    task automatic t_shutup();
        do_write(24'hE8004E, 16'h0000);
        expect_silent(24'hE80000, 1'b1, "R8 hidden after shut-up");
        expect_mem(24'h000000, 1'b1, 1'b0, '0, "R8 shut-up maps nothing");
    endtask

    task automatic t_map_8m_and_nostrap();
        do_reset();
        size_sel = 3'd4;
        do_write(24'hE80048, 16'h8000);
        expect_mem(24'hFFFFFF, 1'b1, 1'b1, 23'h7FFFFF, "R10 8MB top of space");
        expect_mem(24'h7FFFFF, 1'b1, 1'b0, '0, "R10 8MB below base");
        do_reset();
        size_sel = 3'd0;
        do_write(24'hE80048, 16'h1000);
        size_sel = 3'd2;
        expect_read(24'hE80000, 16'hEFFF, "R9 write ignored without strap");
        expect_mem(24'h100000, 1'b1, 1'b0, '0, "R9 no map without strap");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_id_regs();
        t_size_codes();
        t_outside();
        t_other_writes();
        t_map_2m();
        t_reset_after_map();
        t_shutup();
        t_map_8m_and_nostrap();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule